// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block runs the external bus of an 8-bit processor core with a 16-bit address space. The core hands it one request at a time over a valid/ready handshake: a cycle kind, a 16-bit address and, for writes, a data byte. The block then runs the machine cycle on the pins. The upper address byte goes out on pins that carry only address. The lower address byte and the data byte take turns on one shared set of lines. An address-latch strobe lets an external latch keep the low address once the shared lines move to data.

Each cycle runs through three clock states: an address state, a strobe state and a completion state. Wait states go between the strobe state and the completion state for as long as the ready input is low. Every bus cycle reports its kind on an IO/memory line and two status lines. A halt request parks the bus with a halt status code. A hold request hands the bus to another master: every pin driver is released and a grant is returned.

Top module: `mux_bus_ctl`

## Requirements
- R1: After reset, rd_n and wr_n are high, ale is low, no output enable (ad_oe, addr_hi_oe, iom_oe) is set, hlda and rsp_done are low, and req_ready is high.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both high. In the next cycle (the address state), ale is high for exactly one cycle, ad_o carries address bits 7..0 with ad_oe high, and addr_hi_o carries bits 15..8 with addr_hi_oe high. addr_hi_o stays unchanged until the cycle ends.
- R3: From the address state through the completion state, iom_oe is high and {iom, s1, s0} holds the kind's code. The kind codes on req_kind are: 0 opcode fetch = 011, 1 memory read = 010, 2 memory write = 001, 3 I/O read = 110, 4 I/O write = 101, 5 interrupt acknowledge = 111. Outside a bus cycle, iom_oe is low.
- R4: For the read kinds (0, 1, 3, 5), ad_oe is low from the strobe state onward. rd_n is low from the strobe state through the completion state, including any wait states, and wr_n stays high.
- R5: For the write kinds (2, 4), ad_o carries the write data with ad_oe high from the strobe state through the completion state. wr_n is low over the same span, and rd_n stays high.
- R6: If ready is low at the end of the strobe state or of a wait state, one more wait state follows with the strobe still asserted. ready has no effect in any other state.
- R7: In the cycle after the completion state, rsp_done is high for one cycle, both strobes are high, and for a read, rsp_rdata equals ad_i as sampled at the end of the completion state. A write leaves rsp_rdata unchanged.
- R8: Kind 6 or 7 is a halt. The next cycle pulses rsp_done and enters a halted state with iom_oe low, {s1, s0} = 00 and both strobes high. A later request is accepted from the halted state.
- R9: When hold is high while the block is idle or halted, hlda goes high in the next cycle, and ad_oe, addr_hi_oe, strobe_oe and iom_oe are all low. A bus cycle already running finishes before the bus is granted. When hold drops, hlda falls in the next cycle.
- R10: While hold is high, or while a cycle is in progress, req_ready is low and no pending request starts a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Data returned by the last read |
| addr_hi_o | output | 8 | Upper address byte |
| addr_hi_oe | output | 1 | Drive enable for the upper address pins |
| ad_o | output | 8 | Shared lines, output value |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_i | input | 8 | Shared lines, input value |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| strobe_oe | output | 1 | Drive enable for rd_n and wr_n |
| iom | output | 1 | IO/memory status |
| iom_oe | output | 1 | Drive enable for iom |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| ready | input | 1 | Slave ready; low adds wait states |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Hold acknowledge |

## Verification
The bench runs every bus cycle kind against five address patterns: all zeros, all ones, two alternating-bit patterns, and one with distinct nibbles. A dropped or swapped address bit, or the two address bytes being confused, shows up on the latched address. Each combination is run with zero, one and three wait states, which separates strobe timing that ignores ready from timing that follows it. The read data on ad_i is the complement of the expected byte until the completion state, so sampling it one state early is caught. Separate sequences apply halt, hold while idle, hold during a running cycle, and a request left pending during hold.

// File: rtl/mbs_pkg.sv
`timescale 1ns/1ps
package mbs_pkg;

    localparam int KIND_W = 3;

    localparam logic [KIND_W-1:0] KIND_FETCH = 3'd0;
    localparam logic [KIND_W-1:0] KIND_MRD   = 3'd1;
    localparam logic [KIND_W-1:0] KIND_MWR   = 3'd2;
    localparam logic [KIND_W-1:0] KIND_IORD  = 3'd3;
    localparam logic [KIND_W-1:0] KIND_IOWR  = 3'd4;
    localparam logic [KIND_W-1:0] KIND_INTA  = 3'd5;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_T1,
        PH_T2,
        PH_TW,
        PH_T3,
        PH_HALT,
        PH_HOLD
    } phase_e;

    function automatic logic kind_is_write(input logic [KIND_W-1:0] k);
        return (k == KIND_MWR) || (k == KIND_IOWR);
    endfunction

    function automatic logic kind_is_halt(input logic [KIND_W-1:0] k);
        return k[2] & k[1];
    endfunction

    function automatic logic phase_on_bus(input phase_e p);
        return (p == PH_T1) || (p == PH_T2) || (p == PH_TW) || (p == PH_T3);
    endfunction

    function automatic logic phase_strobe(input phase_e p);
        return (p == PH_T2) || (p == PH_TW) || (p == PH_T3);
    endfunction

endpackage

// File: rtl/mbs_status_enc.sv
`timescale 1ns/1ps
module mbs_status_enc
    import mbs_pkg::*;
(
    input  phase_e              phase,
    input  logic [KIND_W-1:0]   kind,
    output logic                iom,
    output logic                iom_oe,
    output logic                s1,
    output logic                s0
);

    logic [2:0] code;

    always_comb begin
        unique case (kind)
            KIND_FETCH: code = 3'b011;
            KIND_MRD:   code = 3'b010;
            KIND_MWR:   code = 3'b001;
            KIND_IORD:  code = 3'b110;
            KIND_IOWR:  code = 3'b101;
            KIND_INTA:  code = 3'b111;
            default:    code = 3'b000;
        endcase
    end

    always_comb begin
        if (phase_on_bus(phase)) begin
            {iom, s1, s0} = code;
            iom_oe        = 1'b1;
        end else begin
            // idle, halt and hold: IO/M floats, status lines at 00
            {iom, s1, s0} = 3'b000;
            iom_oe        = 1'b0;
        end
    end

endmodule

// File: rtl/mbs_pad_mux.sv
`timescale 1ns/1ps
module mbs_pad_mux
    import mbs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  phase_e              phase,
    input  logic [KIND_W-1:0]   kind,
    input  logic [AW-1:0]       addr,
    input  logic [DW-1:0]       wdata,
    output logic [AW-DW-1:0]    addr_hi_o,
    output logic                addr_hi_oe,
    output logic [DW-1:0]       ad_o,
    output logic                ad_oe,
    output logic                ale,
    output logic                rd_n,
    output logic                wr_n,
    output logic                strobe_oe,
    output logic                hlda
);

    logic is_wr;
    logic in_t1;
    logic strobing;

    always_comb begin
        is_wr      = kind_is_write(kind);
        in_t1      = (phase == PH_T1);
        strobing   = phase_strobe(phase);

        addr_hi_o  = addr[AW-1:DW];
        addr_hi_oe = phase_on_bus(phase);

        ale        = in_t1;
        ad_o       = in_t1 ? addr[DW-1:0] : wdata;
        ad_oe      = in_t1 || (strobing && is_wr);

        rd_n       = !(strobing && !is_wr);
        wr_n       = !(strobing && is_wr);

        strobe_oe  = (phase != PH_HOLD);
        hlda       = (phase == PH_HOLD);
    end

endmodule

// File: rtl/mbs_seq.sv
`timescale 1ns/1ps
module mbs_seq
    import mbs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [KIND_W-1:0]   req_kind,
    input  logic [AW-1:0]       req_addr,
    input  logic [DW-1:0]       req_wdata,
    input  logic [DW-1:0]       ad_i,
    input  logic                ready,
    input  logic                hold,
    output phase_e              phase,
    output logic [KIND_W-1:0]   kind,
    output logic [AW-1:0]       addr,
    output logic [DW-1:0]       wdata,
    output logic [DW-1:0]       rdata,
    output logic                done
);

    typedef struct packed {
        phase_e              phase;
        logic [KIND_W-1:0]   kind;
        logic [AW-1:0]       addr;
        logic [DW-1:0]       wdata;
        logic [DW-1:0]       rdata;
        logic                done;
    } seq_t;

    seq_t q, d;
    logic can_take;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        can_take = ((q.phase == PH_IDLE) || (q.phase == PH_HALT)) && !hold;

        unique case (q.phase)
            PH_IDLE, PH_HALT: begin
                if (hold) begin
                    d.phase = PH_HOLD;
                end else if (req_valid) begin
                    d.kind  = req_kind;
                    d.addr  = req_addr;
                    d.wdata = req_wdata;
                    if (kind_is_halt(req_kind)) begin
                        d.phase = PH_HALT;
                        d.done  = 1'b1;
                    end else begin
                        d.phase = PH_T1;
                    end
                end
            end
            PH_T1: d.phase = PH_T2;
            PH_T2, PH_TW: d.phase = ready ? PH_T3 : PH_TW;
            PH_T3: begin
                if (!kind_is_write(q.kind)) begin
                    d.rdata = ad_i;
                end
                d.done  = 1'b1;
                d.phase = PH_IDLE;
            end
            PH_HOLD: begin
                if (!hold) begin
                    d.phase = PH_IDLE;
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.phase <= PH_IDLE;
            q.kind  <= KIND_FETCH;
            q.addr  <= '0;
            q.wdata <= '0;
            q.rdata <= '0;
            q.done  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign req_ready = can_take;
    assign phase     = q.phase;
    assign kind      = q.kind;
    assign addr      = q.addr;
    assign wdata     = q.wdata;
    assign rdata     = q.rdata;
    assign done      = q.done;

    // R6: a low ready at the end of the strobe or a wait state yields a wait state
    a_r6_wait_inserted: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.phase == PH_T2 || q.phase == PH_TW) && !ready) |=> (q.phase == PH_TW));

    // R7: done only follows the completion state or a halt acceptance
    a_r7_done_source: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (($past(q.phase) == PH_T3) || (q.phase == PH_HALT)));

    // R9: hold seen while idle is granted on the next edge
    a_r9_hold_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && q.phase == PH_IDLE) |=> (q.phase == PH_HOLD));

    // R2: address state always advances to the strobe state
    a_r2_t1_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_T1) |=> (q.phase == PH_T2));

endmodule

// File: rtl/mux_bus_ctl.sv
`timescale 1ns/1ps
module mux_bus_ctl
    import mbs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [2:0]          req_kind,
    input  logic [AW-1:0]       req_addr,
    input  logic [DW-1:0]       req_wdata,
    output logic                rsp_done,
    output logic [DW-1:0]       rsp_rdata,
    output logic [AW-DW-1:0]    addr_hi_o,
    output logic                addr_hi_oe,
    output logic [DW-1:0]       ad_o,
    output logic                ad_oe,
    input  logic [DW-1:0]       ad_i,
    output logic                ale,
    output logic                rd_n,
    output logic                wr_n,
    output logic                strobe_oe,
    output logic                iom,
    output logic                iom_oe,
    output logic                s1,
    output logic                s0,
    input  logic                ready,
    input  logic                hold,
    output logic                hlda
);

    phase_e              phase;
    logic [KIND_W-1:0]   kind;
    logic [AW-1:0]       addr;
    logic [DW-1:0]       wdata;

    mbs_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ad_i      (ad_i),
        .ready     (ready),
        .hold      (hold),
        .phase     (phase),
        .kind      (kind),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rsp_rdata),
        .done      (rsp_done)
    );

    mbs_pad_mux #(.AW(AW), .DW(DW)) u_pad (
        .phase      (phase),
        .kind       (kind),
        .addr       (addr),
        .wdata      (wdata),
        .addr_hi_o  (addr_hi_o),
        .addr_hi_oe (addr_hi_oe),
        .ad_o       (ad_o),
        .ad_oe      (ad_oe),
        .ale        (ale),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .strobe_oe  (strobe_oe),
        .hlda       (hlda)
    );

    mbs_status_enc u_stat (
        .phase  (phase),
        .kind   (kind),
        .iom    (iom),
        .iom_oe (iom_oe),
        .s1     (s1),
        .s0     (s0)
    );

    // R2: latch enable is a single-cycle pulse followed by a strobe
    a_r2_ale_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!ale && (!rd_n || !wr_n)));

    // R4: read and write strobes never overlap
    a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R3: status code holds steady across strobe, wait and completion states
    a_r3_status_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> ($stable({iom, s1, s0}) && iom_oe));

    // R9: a granted hold floats every driver
    a_r9_bus_floated: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> !(ad_oe || addr_hi_oe || strobe_oe || iom_oe));

    // R8: halted bus shows status 00 with IO/M released
    a_r8_halt_status: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HALT) |-> (!iom_oe && !s1 && !s0 && rd_n && wr_n));

endmodule

// File: tb/mux_bus_ctl_test.sv
`timescale 1ns/1ps
module mux_bus_ctl_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [2:0]  req_kind;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        rsp_done;
    logic [7:0]  rsp_rdata;
    logic [7:0]  addr_hi_o;
    logic        addr_hi_oe;
    logic [7:0]  ad_o;
    logic        ad_oe;
    logic [7:0]  ad_i;
    logic        ale, rd_n, wr_n, strobe_oe;
    logic        iom, iom_oe, s1, s0;
    logic        ready, hold, hlda;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] last_rd = 8'h00;

    always #4 clk = ~clk;

    mux_bus_ctl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .addr_hi_o(addr_hi_o),
        .addr_hi_oe(addr_hi_oe), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .strobe_oe(strobe_oe),
        .iom(iom), .iom_oe(iom_oe), .s1(s1), .s0(s0),
        .ready(ready), .hold(hold), .hlda(hlda)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_code(input logic [2:0] k);
        case (k)
            3'd0: return 3'b011;
            3'd1: return 3'b010;
            3'd2: return 3'b001;
            3'd3: return 3'b110;
            3'd4: return 3'b101;
            default: return 3'b111;
        endcase
    endfunction

    task automatic do_cycle(input logic [2:0] k, input logic [15:0] a,
                            input logic [7:0] wd, input logic [7:0] rdx, input int nw);
        logic       wr;
        logic [7:0] ext_latch;
        logic [1:0] strb;
        wr   = (k == 3'd2) || (k == 3'd4);
        strb = wr ? 2'b10 : 2'b01;
        ext_latch = 8'hxx;
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
        ready = (nw == 0); ad_i = ~rdx;
        @(negedge clk);
        req_valid = 1'b0;
        // address state
        chk("R2 ale", ale, 1);
        chk("R2 ad_oe", ad_oe, 1);
        chk("R2 ad_o", ad_o, a[7:0]);
        chk("R2 hi_oe", addr_hi_oe, 1);
        chk("R2 hi", addr_hi_o, a[15:8]);
        if (ale) ext_latch = ad_o;
        chk("R3 status", {iom_oe, iom, s1, s0}, {1'b1, exp_code(k)});
        chk("R4 no strobe in T1", {rd_n, wr_n}, 2'b11);
        chk("R10 busy", req_ready, 0);
        @(negedge clk);
        // strobe state
        chk("R2 ale low", ale, 0);
        chk("R2 latched", ext_latch, a[7:0]);
        chk("R2 hi held", addr_hi_o, a[15:8]);
        chk("R3 status", {iom_oe, iom, s1, s0}, {1'b1, exp_code(k)});
        if (wr) begin
            chk("R5 ad_oe", ad_oe, 1);
            chk("R5 wdata", ad_o, wd);
            chk("R5 strobe", {rd_n, wr_n}, strb);
        end else begin
            chk("R4 ad released", ad_oe, 0);
            chk("R4 strobe", {rd_n, wr_n}, strb);
        end
        for (int i = 1; i <= nw; i++) begin
            @(negedge clk);
            chk("R6 wait strobe", {rd_n, wr_n}, strb);
            chk("R6 no done", rsp_done, 0);
            if (wr) chk("R5 wait data", ad_o, wd);
            if (i == nw) ready = 1'b1;
        end
        @(negedge clk);
        // completion state
        chk("R4 T3 strobe", {rd_n, wr_n}, strb);
        chk("R3 T3 status", {iom_oe, iom, s1, s0}, {1'b1, exp_code(k)});
        chk("R7 no early done", rsp_done, 0);
        if (wr) chk("R5 T3 data", {ad_oe, ad_o}, {1'b1, wd});
        ad_i = rdx;
        @(negedge clk);
        chk("R7 done", rsp_done, 1);
        if (!wr) last_rd = rdx;
        chk("R7 rdata", rsp_rdata, last_rd);
        chk("R7 strobes off", {rd_n, wr_n, ad_oe, iom_oe}, 4'b1100);
        chk("R10 ready again", req_ready, 1);
        @(negedge clk);
        chk("R7 done one cycle", rsp_done, 0);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] pats [5];
        int nws [3];
        pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA55A;
        pats[3] = 16'h5AA5; pats[4] = 16'h1234;
        nws[0] = 0; nws[1] = 1; nws[2] = 3;
        rst_n = 1'b0; req_valid = 1'b0; req_kind = 3'd0; req_addr = 16'h0;
        req_wdata = 8'h0; ad_i = 8'h0; ready = 1'b1; hold = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 strobes", {rd_n, wr_n, ale}, 3'b110);
        chk("R1 enables", {ad_oe, addr_hi_oe, iom_oe}, 3'b000);
        chk("R1 hlda/done", {hlda, rsp_done}, 2'b00);
        chk("R1 ready", req_ready, 1);

        // main sweep: every kind x address pattern x wait count
        for (int k = 0; k < 6; k++)
            for (int p = 0; p < 5; p++)
                for (int w = 0; w < 3; w++)
                    do_cycle(k[2:0], pats[p] ^ {8'h00, k[7:0]},
                             pats[p][7:0] ^ 8'h3C, pats[p][15:8] ^ k[7:0] ^ 8'hC3, nws[w]);

        // R8 halt
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'd6;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 halt done", rsp_done, 1);
        chk("R8 halt status", {iom_oe, s1, s0, rd_n, wr_n}, 5'b00011);
        @(negedge clk);
        chk("R8 halt done pulse", rsp_done, 0);
        chk("R8 halt ready", req_ready, 1);
        chk("R8 halt stays", {iom_oe, s1, s0, ale}, 4'b0000);
        do_cycle(3'd1, 16'h4500, 8'h00, 8'h99, 0);

        // R9 hold while halted
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'd7;
        @(negedge clk);
        req_valid = 1'b0; hold = 1'b1;
        @(negedge clk);
        chk("R9 hlda from halt", hlda, 1);
        chk("R9 floated", {ad_oe, addr_hi_oe, strobe_oe, iom_oe}, 4'b0000);
        // R10 pending request during hold is not taken
        req_valid = 1'b1; req_kind = 3'd2; req_addr = 16'hBEEF; req_wdata = 8'h77;
        @(negedge clk);
        chk("R10 not ready in hold", req_ready, 0);
        chk("R10 no cycle in hold", {ale, hlda}, 2'b01);
        hold = 1'b0;
        @(negedge clk);
        chk("R9 hlda drops", hlda, 0);
        chk("R10 still no cycle", ale, 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 pending taken", {ale, ad_o, addr_hi_o}, {1'b1, 8'hEF, 8'hBE});
        repeat (4) @(negedge clk);

        // R9 hold during a running cycle
        req_valid = 1'b1; req_kind = 3'd0; req_addr = 16'h2000; ready = 1'b1; ad_i = 8'h5E;
        @(negedge clk);
        req_valid = 1'b0; hold = 1'b1;
        chk("R9 cycle runs", {ale, hlda}, 2'b10);
        @(negedge clk);
        chk("R9 no grant mid-cycle", {hlda, rd_n}, 2'b00);
        @(negedge clk);
        chk("R9 T3 no grant", {hlda, rd_n}, 2'b00);
        @(negedge clk);
        chk("R9 cycle completes", {rsp_done, rsp_rdata, hlda}, {1'b1, 8'h5E, 1'b0});
        @(negedge clk);
        chk("R9 grant after cycle", {hlda, strobe_oe, addr_hi_oe}, 3'b100);
        hold = 1'b0;
        @(negedge clk);
        chk("R9 released", {hlda, strobe_oe, req_ready}, 3'b011);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule